// File: doc/BRIEF.md
# Valid-Ready Pipeline Stall Controller

This block steers a fixed-depth datapath pipeline that advances as a single unit. It keeps one valid marker per register stage and drives one pipeline enable. The external data registers use that enable as their clock enable, so they need no reset: only the markers are cleared. Both ends of the pipeline use a valid/ready handshake. A word moves across either end only in a cycle where valid and ready are both high.

The whole pipeline moves forward when the final stage is empty or when the consumer is ready for the word held there. Otherwise every stage holds. A clock-enable input freezes the pipeline. While it is low, no word is accepted and none is delivered. The parameter `DEPTH` counts every register stage, including the input and output registers. An input register, then logic, then an output register is a depth of 2.

Top module: `valid_ready_pipe_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after it is released, all markers are zero: `out_valid_o` is 0 and, with `ce_i` high, `in_ready_o` is 1.
- R2: `pipe_en_o` is 1 exactly when `ce_i` is 1 and either the final marker is 0 or `out_ready_i` is 1. A full final stage with `out_ready_i` low stalls the pipeline.
- R3: `in_ready_o` always equals `pipe_en_o`. An upstream word is taken only in a cycle where `in_valid_i` and `in_ready_o` are both 1.
- R4: `out_valid_o` equals the final-stage marker ANDed with `ce_i`.
- R5: On a rising edge where `pipe_en_o` is 1, marker 0 loads `in_valid_i` and each later marker takes the one before it. A word accepted on an enabled edge is offered at the output after exactly `DEPTH` enabled edges.
- R6: On a rising edge where `pipe_en_o` is 0, every marker holds its value.
- R7: While `ce_i` is 0, `pipe_en_o`, `in_ready_o` and `out_valid_o` are all 0.
- R8: Every accepted word is delivered exactly once and in acceptance order. Cycles with `in_valid_i` low that are shifted in produce no output valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low, clears the markers |
| ce_i | input | 1 | Clock enable; low freezes the pipeline |
| in_valid_i | input | 1 | Upstream word is valid |
| in_ready_o | output | 1 | Pipeline takes the upstream word |
| out_valid_o | output | 1 | Final-stage word is valid |
| out_ready_i | input | 1 | Consumer takes the final-stage word |
| pipe_en_o | output | 1 | Clock enable for the external data registers |

## Verification
`in_ready_o`, `pipe_en_o` and `out_valid_o` are combinational in the current inputs and the present markers. The bench drives inputs just after a falling edge and samples these outputs one time unit later, before the next rising edge. A marker change appears in the outputs one rising edge later, and the bench checks it in the following half cycle. An accepted word reaches `out_valid_o` only after `DEPTH` edges on which the pipeline enable is high. The bench counts those enabled edges and, at delivery, compares the count with the one stored at acceptance.

// File: rtl/pipe_ctrl_pkg.sv
package pipe_ctrl_pkg;
  // final stage can take a new word
  function automatic logic stage_free(input logic last_vld, input logic down_rdy);
    return !last_vld || down_rdy;
  endfunction
endpackage

// File: rtl/pipe_valid_chain.sv
module pipe_valid_chain #(
  parameter int unsigned DEPTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             din_i,
  output logic [DEPTH-1:0] vld_o
);
  logic [DEPTH-1:0] vld_q;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   vld_q <= '0;
        else if (en_i) vld_q <= din_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   vld_q <= '0;
        else if (en_i) vld_q <= {vld_q[DEPTH-2:0], din_i};
      end
    end
  endgenerate

  assign vld_o = vld_q;
endmodule

// File: rtl/pipe_flags.sv
module pipe_flags (
  input  logic last_vld_i,
  input  logic ce_i,
  input  logic out_ready_i,
  output logic pipe_en_o,
  output logic in_ready_o,
  output logic out_valid_o
);
  import pipe_ctrl_pkg::*;

  logic free;

  always_comb begin
    free        = stage_free(last_vld_i, out_ready_i);
    pipe_en_o   = free && ce_i;
    in_ready_o  = free && ce_i;
    out_valid_o = last_vld_i && ce_i;
  end
endmodule

// File: rtl/valid_ready_pipe_ctrl.sv
module valid_ready_pipe_ctrl #(
  parameter int unsigned DEPTH = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  input  logic in_valid_i,
  output logic in_ready_o,
  output logic out_valid_o,
  input  logic out_ready_i,
  output logic pipe_en_o
);
  localparam int unsigned LAST = DEPTH - 1;

  logic [DEPTH-1:0] vld;
  logic             en;

  pipe_flags u_flags (
    .last_vld_i  (vld[LAST]),
    .ce_i        (ce_i),
    .out_ready_i (out_ready_i),
    .pipe_en_o   (en),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o)
  );

  pipe_valid_chain #(.DEPTH(DEPTH)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .din_i  (in_valid_i),
    .vld_o  (vld)
  );

  assign pipe_en_o = en;
endmodule

// File: rtl/valid_ready_pipe_ctrl_chk.sv
module valid_ready_pipe_ctrl_chk #(
  parameter int unsigned DEPTH = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ce_i,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic             pipe_en_o,
  input logic [DEPTH-1:0] vld
);
  AST_STALL_ON_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld[DEPTH-1] && !out_ready_i) |-> !pipe_en_o); // R2
  AST_READY_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o == pipe_en_o); // R3
  AST_OUT_FROM_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (vld[DEPTH-1] && ce_i)); // R4
  AST_SHIFT_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pipe_en_o |=> (vld[0] == $past(in_valid_i))); // R5
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pipe_en_o |=> $stable(vld)); // R6
  AST_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |-> (!pipe_en_o && !in_ready_o && !out_valid_o)); // R7
endmodule

bind valid_ready_pipe_ctrl valid_ready_pipe_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ce_i        (ce_i),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .pipe_en_o   (pipe_en_o),
  .vld         (vld)
);

// File: tb/sim_valid_ready_pipe_ctrl.sv
`timescale 1ns/1ps
module sim_valid_ready_pipe_ctrl;
  localparam int DEPTH = 3;
  localparam int NVEC  = 12;
  // {ce, in_valid, out_ready, exp_in_ready, exp_out_valid}, hand-derived for DEPTH 3 from reset
  localparam logic [4:0] VEC [NVEC] = '{
    5'b11010, 5'b10010, 5'b11010, 5'b11001, 5'b01100, 5'b10111,
    5'b10010, 5'b10001, 5'b11111, 5'b10110, 5'b10110, 5'b10111
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ce, iv, ordy;
  logic in_ready, out_valid, pipe_en;
  int   n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  valid_ready_pipe_ctrl #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ce_i(ce), .in_valid_i(iv),
    .in_ready_o(in_ready), .out_valid_o(out_valid), .out_ready_i(ordy),
    .pipe_en_o(pipe_en)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // bench-side data registers clocked by pipe_en, plus scoreboard
  int d [DEPTH];
  int exp_q [$];
  int tag_q [$];
  int en_cnt = 0;
  int next_id = 1;

  task automatic step(input logic c, input logic v, input logic r);
    logic acc, del, en;
    @(negedge clk);
    ce = c; iv = v; ordy = r;
    #1;
    acc = iv && in_ready;
    del = out_valid && ordy;
    en  = pipe_en;
    chk(in_ready == pipe_en, "R3 ready equals enable", in_ready, pipe_en);
    if (!c) chk(!pipe_en && !out_valid, "R7 frozen", {pipe_en, out_valid}, 0);
    if (del) begin
      if (exp_q.size() == 0) chk(1'b0, "R8 spurious delivery", 1, 0);
      else begin
        int e, t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(d[DEPTH-1] == e, "R8 order", d[DEPTH-1], e);
        chk(en_cnt - t == DEPTH, "R5 latency", en_cnt - t, DEPTH);
      end
    end
    @(posedge clk);
    if (en) begin
      for (int k = DEPTH-1; k > 0; k--) d[k] = d[k-1];
      d[0] = next_id;
    end
    if (acc) begin
      exp_q.push_back(next_id);
      tag_q.push_back(en_cnt);
    end
    next_id++;
    if (en) en_cnt++;
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    ce = 1'b1; iv = 1'b0; ordy = 1'b0;
    #1;
    chk(!out_valid, "R1 out_valid in reset", out_valid, 0);
    chk(in_ready, "R1 in_ready in reset", in_ready, 1);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk(!out_valid && in_ready, "R1 after release", {out_valid, in_ready}, 1);

    // table walk: R2 R4 R6 R7 covered by hand-derived expectations
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      ce = VEC[i][4]; iv = VEC[i][3]; ordy = VEC[i][2];
      #1;
      chk(in_ready == VEC[i][1], $sformatf("R2 vec %0d in_ready", i), in_ready, VEC[i][1]);
      chk(pipe_en == VEC[i][1], $sformatf("R3 vec %0d pipe_en", i), pipe_en, VEC[i][1]);
      chk(out_valid == VEC[i][0], $sformatf("R4 R6 vec %0d out_valid", i), out_valid, VEC[i][0]);
    end
    @(posedge clk);

    // random traffic with scoreboard: R5 R8
    for (int i = 0; i < 3000; i++)
      step(($urandom % 8) != 0, ($urandom % 3) != 0, ($urandom % 4) != 0);
    for (int i = 0; i < DEPTH + 2; i++) step(1'b1, 1'b0, 1'b1);
    chk(exp_q.size() == 0, "R8 all delivered once", exp_q.size(), 0);

    // R6: a frozen full stage holds across several edges
    step(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < DEPTH + 2; i++) step(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1);
    @(negedge clk); ce = 1'b1; ordy = 1'b0; iv = 1'b0; #1;
    chk(out_valid && !in_ready, "R6 held final word", {out_valid, in_ready}, 2);

    // R1: mid-run reset clears markers
    rst_ni = 1'b0;
    #1;
    chk(!out_valid && in_ready, "R1 mid-run reset", {out_valid, in_ready}, 1);
    @(negedge clk); rst_ni = 1'b1; #1;
    chk(!out_valid, "R1 after second release", out_valid, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule